// File: doc/BRIEF.md
# DMA Error Status and Resume Register

This block is one 32-bit control/status word that sits beside a descriptor-driven DMA engine in an SD host controller. The engine reports on its work by pulsing dedicated set inputs: an end-of-transfer flag, a length-mismatch flag, a descriptor-interrupt flag and a two-bit error state code. Software reads the word back through a little-endian register port at any byte-lane offset. It writes the word with byte, halfword or word accesses.

Some bits in the word need special handling. The end-of-transfer flag can only be set by the engine. The descriptor-interrupt flag is cleared by writing 1 to it. A continue-request bit is never stored. A small state machine tracks whether the engine is paused at an interrupting descriptor, and it turns an accepted continue request into a one-cycle resume pulse. The state machine has three states:

- `RS_RUN`: the engine is not waiting. It moves to `RS_PAUSED` on a descriptor-interrupt pulse.
- `RS_PAUSED`: the engine waits for software. It moves to `RS_RESUME` on an accepted continue request.
- `RS_RESUME`: the resume pulse is high for one cycle. It returns to `RS_RUN`, or to `RS_PAUSED` if another descriptor-interrupt pulse arrives in that cycle.

Top module: `dma_err_status_reg`

## Requirements
- R1: After reset the stored word reads 0, `paused` is 0 and `resume_pulse` is 0.
- R2: Bit 10 is the end-of-transfer flag. `eng_final_set` sets it. A qualified write (see R7) never changes it.
- R3: Bit 9 is the continue request. It is never stored, so every read returns 0 in that bit position.
- R4: Bit 8 is the descriptor-interrupt flag. In a qualified write, a 1 in bit 8 clears the flag and a 0 in bit 8 leaves it unchanged.
- R5: A resume is accepted when all three of these hold in the same cycle: a qualified write has a 1 in bit 9, the state is paused, and `dma_mode` equals 2'b10 (32-bit advanced descriptor mode). The resume raises `resume_pulse` for exactly one cycle, in the cycle after the write, and clears `paused`. In any other case the write causes no pulse.
- R6: `eng_desc_irq_set` sets bit 8 and, from the running state, makes `paused` read 1 from the next cycle.
- R7: A write is qualified when it is one of the following:
  - a word at offset 0, which replaces all bits except 10, 9 and 8;
  - a halfword at offset 0, which replaces bits 15:0 except 10, 9 and 8, and keeps bits 31:16;
  - a byte at offset 1, which places the data in bits 15:8 (except 10, 9 and 8) and keeps all other bits.

  Size codes are 2'b00 for byte, 2'b01 for halfword, and 2'b10 or 2'b11 for word.
- R8: Every other size/offset combination is a plain merge. Data byte k goes to lane offset+k, lanes past 3 are dropped, and bits 8 and 10 are written like any other bit. Bit 9 still stays 0.
- R9: `eng_xfer_start` clears bit 10 and bit 2 (the length-mismatch flag).
- R10: `rd_data` equals the stored word shifted right by 8×`rd_off`, masked to the width given by `rd_size`.
- R11: When an engine set pulse and a software clear (a write or a transfer start) hit the same bit in the same cycle, the bit ends at 1.
- R12: `eng_state_load` loads `eng_state` into bits 1:0, and `eng_len_err_set` sets bit 2. Qualified and plain writes may overwrite both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 2 | Byte offset of the write |
| wr_size | input | 2 | Write size: 00 byte, 01 halfword, 1x word |
| wr_data | input | 32 | Write data, right-aligned |
| rd_off | input | 2 | Byte offset of the read |
| rd_size | input | 2 | Read size, same encoding as the write size |
| rd_data | output | 32 | Shifted and masked read data |
| dma_mode | input | MODE_W | DMA-type selector from the host control field |
| eng_xfer_start | input | 1 | Engine starts a transfer |
| eng_final_set | input | 1 | Engine sets the end-of-transfer flag |
| eng_len_err_set | input | 1 | Engine sets the length-mismatch flag |
| eng_desc_irq_set | input | 1 | Engine hit an interrupting descriptor |
| eng_state_load | input | 1 | Engine loads the error state code |
| eng_state | input | STATE_W | Error state code value |
| resume_pulse | output | 1 | One-cycle request to the engine to continue |
| paused | output | 1 | Engine is waiting for a continue request |

## Verification
Two things can collide in a single cycle, and the bench drives both on the same edge.

- An engine set pulse and a software write that would clear the same bit. The bench pulses `eng_desc_irq_set` alongside a word write carrying a 1 in bit 8, and pulses `eng_xfer_start` alongside `eng_final_set`. A correct result is the flag reading 1 afterwards.
- A continue request and a pause. The bench checks that the pulse appears only in the paused state with the right mode, and that a descriptor-interrupt pulse in the resume cycle leads straight back to paused.

A behavioural model in the bench is compared with the read port and both outputs on every cycle.

// File: rtl/dmaerr_pkg.sv
package dmaerr_pkg;
    localparam int REG_W      = 32;
    localparam int LANES      = REG_W / 8;
    localparam int OFF_W      = $clog2(LANES);
    localparam int BIT_FINAL  = 10;
    localparam int BIT_CONT   = 9;
    localparam int BIT_DIRQ   = 8;
    localparam int BIT_LENERR = 2;

    localparam logic [REG_W-1:0] PROT_MASK =
        (REG_W'(1) << BIT_FINAL) | (REG_W'(1) << BIT_CONT) | (REG_W'(1) << BIT_DIRQ);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRSV = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        RS_RUN    = 2'b00,
        RS_PAUSED = 2'b01,
        RS_RESUME = 2'b10
    } resume_state_e;

    function automatic logic [REG_W-1:0] size_mask(input logic [1:0] sz);
        unique case (acc_size_e'(sz))
            SZ_BYTE: size_mask = REG_W'(32'h0000_00FF);
            SZ_HALF: size_mask = REG_W'(32'h0000_FFFF);
            default: size_mask = '1;
        endcase
    endfunction
endpackage

// File: rtl/dmaerr_wr_decode.sv
module dmaerr_wr_decode
    import dmaerr_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    input  logic [REG_W-1:0] data,
    output logic             qualified,
    output logic             cont_req,
    output logic [REG_W-1:0] data_al,
    output logic [REG_W-1:0] merge_mask,
    output logic [REG_W-1:0] w1c_mask
);
    logic [REG_W-1:0] smask;
    logic [REG_W-1:0] lane_mask;
    logic [4:0]       shamt;

    always_comb begin
        smask     = size_mask(size);
        shamt     = {off, 3'b000};
        data_al   = (data & smask) << shamt;
        lane_mask = smask << shamt;
        qualified = ((off == '0) && (acc_size_e'(size) != SZ_BYTE)) ||
                    ((off == OFF_W'(1)) && (acc_size_e'(size) == SZ_BYTE));
        if (qualified) begin
            merge_mask = lane_mask & ~PROT_MASK;
            w1c_mask   = data_al & (REG_W'(1) << BIT_DIRQ);
            cont_req   = data_al[BIT_CONT];
        end else begin
            merge_mask = lane_mask & ~(REG_W'(1) << BIT_CONT);
            w1c_mask   = '0;
            cont_req   = 1'b0;
        end
    end
endmodule

// File: rtl/dmaerr_status_store.sv
module dmaerr_status_store
    import dmaerr_pkg::*;
#(
    parameter int STATE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   data_al,
    input  logic [REG_W-1:0]   merge_mask,
    input  logic [REG_W-1:0]   w1c_mask,
    input  logic               eng_xfer_start,
    input  logic               eng_final_set,
    input  logic               eng_len_err_set,
    input  logic               eng_desc_irq_set,
    input  logic               eng_state_load,
    input  logic [STATE_W-1:0] eng_state,
    output logic [REG_W-1:0]   status_q
);
    logic [REG_W-1:0] status_d;

    always_comb begin
        status_d = status_q;
        if (wr_en) begin
            status_d = (status_q & ~merge_mask) | (data_al & merge_mask);
            status_d = status_d & ~w1c_mask;
        end
        if (eng_xfer_start) begin
            status_d[BIT_FINAL]  = 1'b0;
            status_d[BIT_LENERR] = 1'b0;
        end
        if (eng_state_load)   status_d[STATE_W-1:0] = eng_state;
        if (eng_len_err_set)  status_d[BIT_LENERR]  = 1'b1;
        if (eng_final_set)    status_d[BIT_FINAL]   = 1'b1;
        if (eng_desc_irq_set) status_d[BIT_DIRQ]    = 1'b1;
        status_d[BIT_CONT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/dmaerr_resume_fsm.sv
module dmaerr_resume_fsm
    import dmaerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resume_req,
    input  logic pause_set,
    output logic resume_pulse,
    output logic paused
);
    resume_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_RUN:    if (pause_set)  state_d = RS_PAUSED;
            RS_PAUSED: if (resume_req) state_d = RS_RESUME;
            RS_RESUME: state_d = pause_set ? RS_PAUSED : RS_RUN;
            default:   state_d = RS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        resume_pulse = (state_q == RS_RESUME);
        paused       = (state_q == RS_PAUSED);
    end
endmodule

// File: rtl/dma_err_status_reg.sv
module dma_err_status_reg
    import dmaerr_pkg::*;
#(
    parameter int              MODE_W     = 2,
    parameter logic [MODE_W-1:0] ADV32_MODE = MODE_W'(2),
    parameter int              STATE_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_off,
    input  logic [1:0]         wr_size,
    input  logic [31:0]        wr_data,
    input  logic [1:0]         rd_off,
    input  logic [1:0]         rd_size,
    output logic [31:0]        rd_data,
    input  logic [MODE_W-1:0]  dma_mode,
    input  logic               eng_xfer_start,
    input  logic               eng_final_set,
    input  logic               eng_len_err_set,
    input  logic               eng_desc_irq_set,
    input  logic               eng_state_load,
    input  logic [STATE_W-1:0] eng_state,
    output logic               resume_pulse,
    output logic               paused
);
    logic             qualified;
    logic             cont_req;
    logic [REG_W-1:0] data_al;
    logic [REG_W-1:0] merge_mask;
    logic [REG_W-1:0] w1c_mask;
    logic [REG_W-1:0] status_q;
    logic             resume_req;

    dmaerr_wr_decode u_dec (
        .size       (wr_size),
        .off        (wr_off),
        .data       (wr_data),
        .qualified  (qualified),
        .cont_req   (cont_req),
        .data_al    (data_al),
        .merge_mask (merge_mask),
        .w1c_mask   (w1c_mask)
    );

    dmaerr_status_store #(.STATE_W(STATE_W)) u_store (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .data_al          (data_al),
        .merge_mask       (merge_mask),
        .w1c_mask         (w1c_mask),
        .eng_xfer_start   (eng_xfer_start),
        .eng_final_set    (eng_final_set),
        .eng_len_err_set  (eng_len_err_set),
        .eng_desc_irq_set (eng_desc_irq_set),
        .eng_state_load   (eng_state_load),
        .eng_state        (eng_state),
        .status_q         (status_q)
    );

    assign resume_req = wr_en && qualified && cont_req && (dma_mode == ADV32_MODE);

    dmaerr_resume_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .resume_req   (resume_req),
        .pause_set    (eng_desc_irq_set),
        .resume_pulse (resume_pulse),
        .paused       (paused)
    );

    always_comb begin
        rd_data = (status_q >> {rd_off, 3'b000}) & size_mask(rd_size);
    end
endmodule

// File: rtl/dmaerr_checker.sv
module dmaerr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        eng_final_set,
    input logic        eng_desc_irq_set,
    input logic        eng_len_err_set,
    input logic [31:0] status_q,
    input logic        resume_pulse,
    input logic        paused
);
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

    p_pulse_from_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_pulse) |-> $past(paused));

    p_pulse_unpauses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> !paused);

    p_cont_never_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[9]);

    p_final_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_final_set |=> status_q[10]);

    p_irq_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_desc_irq_set |=> status_q[8]);

    p_lenerr_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_len_err_set |=> status_q[2]);

    p_pause_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(eng_desc_irq_set));
endmodule

bind dma_err_status_reg dmaerr_checker u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .eng_final_set    (eng_final_set),
    .eng_desc_irq_set (eng_desc_irq_set),
    .eng_len_err_set  (eng_len_err_set),
    .status_q         (status_q),
    .resume_pulse     (resume_pulse),
    .paused           (paused)
);

// File: tb/tb_dma_err_status_reg.sv
module tb_dma_err_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_off = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_off = '0;
    logic [1:0]  rd_size = 2'b10;
    logic [31:0] rd_data;
    logic [1:0]  dma_mode = '0;
    logic        eng_xfer_start = 1'b0;
    logic        eng_final_set = 1'b0;
    logic        eng_len_err_set = 1'b0;
    logic        eng_desc_irq_set = 1'b0;
    logic        eng_state_load = 1'b0;
    logic [1:0]  eng_state = '0;
    logic        resume_pulse;
    logic        paused;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int unsigned m_reg = 0;
    int          m_st = 0;  // 0 running, 1 paused, 2 resuming

    always #5 clk = ~clk;

    dma_err_status_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
        .wr_size(wr_size), .wr_data(wr_data), .rd_off(rd_off),
        .rd_size(rd_size), .rd_data(rd_data), .dma_mode(dma_mode),
        .eng_xfer_start(eng_xfer_start), .eng_final_set(eng_final_set),
        .eng_len_err_set(eng_len_err_set), .eng_desc_irq_set(eng_desc_irq_set),
        .eng_state_load(eng_state_load), .eng_state(eng_state),
        .resume_pulse(resume_pulse), .paused(paused)
    );

    task automatic chk(input string req, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic int nbytes(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic int unsigned exp_read(input int unsigned q, input int off, input int sz);
        int unsigned r = q >> (8 * off);
        if (nbytes(sz) < 4) r = r % (32'd1 << (8 * nbytes(sz)));
        return r;
    endfunction

    function automatic int unsigned model_write(input int unsigned q_in, input int sz,
                                                input int off, input int unsigned wd,
                                                output bit cont);
        int unsigned q = q_in;
        int nb = nbytes(sz);
        int unsigned d = wd;
        bit qual = (off == 0 && sz != 0) || (off == 1 && sz == 0);
        if (nb < 4) d = wd % (32'd1 << (8 * nb));
        cont = 1'b0;
        if (qual) begin
            int unsigned dd = d << (8 * off);
            int unsigned span = (nb == 4) ? 32'hFFFF_FFFF : (((32'd1 << (8 * nb)) - 1) << (8 * off));
            int unsigned keep_bits = 32'h0000_0700;
            cont = dd[9];
            q = (q & ~(span & ~keep_bits)) | (dd & span & ~keep_bits);
            if (dd[8]) q[8] = 1'b0;
        end else begin
            for (int b = 0; b < nb; b++)
                if (off + b < 4) q[8*(off+b) +: 8] = d[8*b +: 8];
            q[9] = 1'b0;
        end
        return q;
    endfunction

    task automatic tick();
        int unsigned q = m_reg;
        bit cont = 1'b0;
        int st = m_st;
        if (wr_en) q = model_write(q, int'(wr_size), int'(wr_off), wr_data, cont);
        if (eng_xfer_start) begin q[10] = 1'b0; q[2] = 1'b0; end
        if (eng_state_load) q[1:0] = eng_state;
        if (eng_len_err_set) q[2] = 1'b1;
        if (eng_final_set) q[10] = 1'b1;
        if (eng_desc_irq_set) q[8] = 1'b1;
        q[9] = 1'b0;
        case (m_st)
            0: if (eng_desc_irq_set) st = 1;
            1: if (wr_en && cont && dma_mode == 2'b10) st = 2;
            default: st = eng_desc_irq_set ? 1 : 0;
        endcase
        @(posedge clk);
        @(negedge clk);
        m_reg = q;
        m_st = st;
        wr_en = 1'b0; eng_xfer_start = 1'b0; eng_final_set = 1'b0;
        eng_len_err_set = 1'b0; eng_desc_irq_set = 1'b0; eng_state_load = 1'b0;
        chk("R10 R2 R3 R4 R7 R8 R9 R11 R12 model read", rd_data,
            exp_read(m_reg, int'(rd_off), int'(rd_size)));
        chk("R5 model pulse", resume_pulse, (m_st == 2));
        chk("R6 model paused", paused, (m_st == 1));
    endtask

    task automatic wr(input int sz, input int off, input int unsigned d);
        wr_en = 1'b1; wr_size = 2'(sz); wr_off = 2'(off); wr_data = d;
    endtask

    task automatic rd_word_check(input string req, input int unsigned exp);
        rd_off = 2'd0; rd_size = 2'b10;
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_reg = 0; m_st = 0;
        rd_word_check("R1 reset value", 0);
        chk("R1 reset paused", paused, 0);
        chk("R1 reset pulse", resume_pulse, 0);

        wr(2, 0, 32'hFFFF_FFFF); tick();
        rd_word_check("R7 R2 R3 word write protected bits", 32'hFFFF_F8FF);

        eng_final_set = 1'b1; eng_desc_irq_set = 1'b1; tick();
        rd_word_check("R2 R6 engine sets", 32'hFFFF_FDFF);
        chk("R6 paused after irq", paused, 1);

        wr(2, 0, 32'h0); tick();
        rd_word_check("R4 write 0 keeps bit8", 32'h0000_0500);
        wr(2, 0, 32'h100); tick();
        rd_word_check("R4 write 1 clears bit8", 32'h0000_0400);

        eng_desc_irq_set = 1'b1; tick();
        dma_mode = 2'b00; wr(2, 0, 32'h200); tick();
        chk("R5 wrong mode no pulse", resume_pulse, 0);
        chk("R5 wrong mode stays paused", paused, 1);
        dma_mode = 2'b10; wr(2, 0, 32'h200); tick();
        chk("R5 pulse", resume_pulse, 1);
        chk("R5 unpaused", paused, 0);
        rd_word_check("R3 cont not stored", 32'h0000_0500);
        tick();
        chk("R5 pulse one cycle", resume_pulse, 0);
        wr(2, 0, 32'h200); tick();
        chk("R5 no pulse when running", resume_pulse, 0);

        wr(2, 0, 32'hA5A5_0000); tick();
        wr(1, 0, 32'h1234_0003); tick();
        rd_word_check("R7 half at 0 keeps upper", 32'hA5A5_0503);
        wr(0, 1, 32'h0000_00FF); tick();
        rd_word_check("R7 byte at 1 shifted", 32'hA5A5_FC03);

        wr(0, 2, 32'h3C); tick();
        rd_word_check("R8 plain byte at 2", 32'hA53C_FC03);
        wr(1, 1, 32'h0102); tick();
        rd_word_check("R8 plain half at 1", 32'hA501_0003);
        wr(0, 0, 32'h77); tick();
        rd_word_check("R8 plain byte at 0", 32'hA501_0077);
        wr(1, 1, 32'h0004); tick();
        rd_word_check("R8 plain write sets bit10", 32'hA500_0477);

        eng_xfer_start = 1'b1; tick();
        rd_word_check("R9 start clears", 32'hA500_0073);
        eng_xfer_start = 1'b1; eng_final_set = 1'b1; tick();
        rd_word_check("R11 start vs final set", 32'hA500_0473);

        rd_off = 2'd3; rd_size = 2'b00; #1;
        chk("R10 byte read at 3", rd_data, 32'hA5);
        rd_off = 2'd1; rd_size = 2'b01; #1;
        chk("R10 half read at 1", rd_data, 32'h0004);

        rd_off = 2'd0; rd_size = 2'b10;
        wr(2, 0, 32'h100); eng_desc_irq_set = 1'b1; tick();
        rd_word_check("R11 irq set beats w1c", 32'h0000_0500);
        chk("R6 paused from run", paused, 1);

        eng_state_load = 1'b1; eng_state = 2'b11; eng_len_err_set = 1'b1; tick();
        rd_word_check("R12 state and length flag", 32'h0000_0507);
        wr(2, 0, 32'h0); tick();
        rd_word_check("R12 software overwrite", 32'h0000_0500);

        dma_mode = 2'b10; wr(2, 0, 32'h200); tick();
        chk("R5 pulse again", resume_pulse, 1);
        eng_desc_irq_set = 1'b1; tick();
        chk("R6 irq in resume cycle repauses", paused, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule